// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog timer whose counting logic runs on its own slow clock, separate from the bus clock used by software. Software sees five word locations on the bus side: a command word that accepts magic values, a 3-bit divider setting, a 12-bit restart value, a 12-bit window limit and a status word. A down-counter fed by a programmable divider issues a one-cycle reset pulse when it runs out. Software keeps the system alive by writing the restart command before that happens. When the window limit is below its maximum, a restart that comes too early also triggers the reset pulse.

The three setting words are protected. A special command value opens them for writing, and any other command value closes them again. Each accepted setting write is handed to the slow clock domain through a toggle handshake. While that handover is in flight, a per-setting busy bit is visible in the status word, and further writes to that setting are dropped. Start and restart commands reach the slow domain through the same kind of handshake. Once started, the counter cannot be halted by anything short of a slow-domain reset.

Top module: `iwdg_top`

## Requirements
- R1: After reset the divider setting reads 0, the restart value reads 4095, the window limit reads 4095, the status word reads 0 and `wd_reset` is low.
- R2: Setting writes are accepted only after the command value 0x5555 has been written. Without it they leave the stored value unchanged.
- R3: Writing any command value other than 0x5555 (including start and restart) closes the settings again, so later setting writes are ignored.
- R4: Status bit 0 flags a divider transfer in flight, bit 1 a restart-value transfer and bit 2 a window transfer. A bit is 1 from the cycle after its accepted write until the slow domain has taken the value. When no transfer is in flight, status reads 0.
- R5: A setting write issued while that setting's busy bit is 1 is ignored.
- R6: The command value 0xCCCC starts counting. No reset pulse occurs before start, and after start no command value stops the counter.
- R7: The divider ratio is 4 shifted left by the divider setting. From a start or restart with restart value N, the pulse follows after (N+1)·4·2^setting slow cycles plus the 4-cycle handover latency.
- R8: The command value 0xAAAA reloads the counter from the restart value and clears the divider phase. Restarting more often than the timeout prevents any reset pulse.
- R9: On expiry `wd_reset` is high for exactly one slow cycle, and the counter then reloads, so pulses repeat every (N+1)·ratio slow cycles.
- R10: With the window limit below 4095, a restart arriving while the counter is above the limit raises `wd_reset` at once. A restart at or below the limit does not.
- R11: Addresses are 0 command (reads 0), 1 divider, 2 restart value, 3 window, 4 status. Read data appears with `rd_valid` one bus cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| wd_clk | input | 1 | Slow watchdog clock |
| wd_rst | input | 1 | Synchronous active-high reset, slow domain |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 3 | Word address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| rd_valid | output | 1 | Read data valid |
| wd_reset | output | 1 | One-cycle reset pulse, slow domain |

## Verification
Two functions can collide in one slow cycle: the counter expiring or decrementing, and a restart command landing from the bus domain. In the same cycle the restart is also compared against the window limit. The bench first waits for an expiry pulse, so that the counter is known to be back at its restart value. It then issues a restart, which must produce an immediate window pulse. A second restart is timed to land once the count has dropped to the limit, and it must produce no pulse, only a full-period timeout measured in slow cycles.

// File: rtl/iwdg_pkg.sv
package iwdg_pkg;
  localparam logic [15:0] KEY_OPEN    = 16'h5555;
  localparam logic [15:0] KEY_RESTART = 16'hAAAA;
  localparam logic [15:0] KEY_GO      = 16'hCCCC;

  localparam logic [2:0] A_CMD    = 3'd0;
  localparam logic [2:0] A_DIV    = 3'd1;
  localparam logic [2:0] A_RELOAD = 3'd2;
  localparam logic [2:0] A_WIN    = 3'd3;
  localparam logic [2:0] A_STATUS = 3'd4;
endpackage

// File: rtl/iwdg_xfer.sv
// Toggle handshake that moves one word from the bus domain to the slow domain.
module iwdg_xfer #(
  parameter int W = 12,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         src_clk,
  input  logic         src_rst,
  input  logic         src_load,
  input  logic [W-1:0] src_data,
  output logic         src_busy,
  input  logic         dst_clk,
  input  logic         dst_rst,
  output logic [W-1:0] dst_data,
  output logic         dst_pulse
);
  logic         req_t, ack_s1, ack_s2;
  logic [W-1:0] data_q;
  logic         req_s1, req_s2, req_s3, ack_t;

  assign src_busy = req_t ^ ack_s2;

  always_ff @(posedge src_clk) begin
    if (src_rst) begin
      req_t  <= 1'b0;
      ack_s1 <= 1'b0;
      ack_s2 <= 1'b0;
      data_q <= RST_VAL;
    end else begin
      ack_s1 <= ack_t;
      ack_s2 <= ack_s1;
      if (src_load && !src_busy) begin
        req_t  <= ~req_t;
        data_q <= src_data;
      end
    end
  end

  always_ff @(posedge dst_clk) begin
    if (dst_rst) begin
      req_s1    <= 1'b0;
      req_s2    <= 1'b0;
      req_s3    <= 1'b0;
      ack_t     <= 1'b0;
      dst_pulse <= 1'b0;
      dst_data  <= RST_VAL;
    end else begin
      req_s1    <= req_t;
      req_s2    <= req_s1;
      req_s3    <= req_s2;
      ack_t     <= req_s3;
      dst_pulse <= req_s2 ^ req_s3;
      if (req_s2 ^ req_s3) dst_data <= data_q;
    end
  end

  // The captured word must match the held source word when it is announced.
  assert_xfer_word_held_R4: assert property (@(posedge dst_clk) disable iff (dst_rst)
    dst_pulse |-> dst_data == data_q);
endmodule

// File: rtl/iwdg_core.sv
// Slow-domain divider and down-counter.
module iwdg_core #(
  parameter int PRE_W = 3,
  parameter int CNT_W = 12
) (
  input  logic             wd_clk,
  input  logic             wd_rst,
  input  logic [PRE_W-1:0] div_sel,
  input  logic [CNT_W-1:0] reload_v,
  input  logic [CNT_W-1:0] window_v,
  input  logic             cfg_upd,
  input  logic             go_p,
  input  logic             restart_p,
  output logic             wd_reset
);
  localparam int PRE_CW = (1 << PRE_W) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic              running;
  logic [CNT_W-1:0]  cnt;
  logic [PRE_CW-1:0] pre_cnt;
  logic [PRE_CW:0]   div_v;
  logic              tick, win_hit, load;

  always_comb begin
    div_v   = (PRE_CW + 1)'(4) << div_sel;
    tick    = running && ({1'b0, pre_cnt} >= div_v - 1'b1);
    win_hit = restart_p && running && (window_v != CNT_MAX) && (cnt > window_v);
    load    = restart_p || (go_p && !running);
  end

  always_ff @(posedge wd_clk) begin
    if (wd_rst) begin
      running  <= 1'b0;
      cnt      <= CNT_MAX;
      pre_cnt  <= '0;
      wd_reset <= 1'b0;
    end else begin
      wd_reset <= 1'b0;
      if (go_p) running <= 1'b1;
      if (load) begin
        cnt     <= reload_v;
        pre_cnt <= '0;
        if (win_hit) wd_reset <= 1'b1;
      end else if (running) begin
        if (tick) begin
          pre_cnt <= '0;
          if (cnt == '0) begin
            wd_reset <= 1'b1;
            cnt      <= reload_v;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end else if (cfg_upd) begin
          pre_cnt <= '0;
        end else begin
          pre_cnt <= pre_cnt + 1'b1;
        end
      end
    end
  end

  assert_no_pulse_idle_R6: assert property (@(posedge wd_clk) disable iff (wd_rst)
    wd_reset |-> running);
  assert_never_stops_R6: assert property (@(posedge wd_clk) disable iff (wd_rst)
    running |=> running);
  assert_expiry_pulse_R9: assert property (@(posedge wd_clk) disable iff (wd_rst)
    (tick && cnt == '0 && !load) |=> (wd_reset && cnt == $past(reload_v)));
  assert_open_window_quiet_R10: assert property (@(posedge wd_clk) disable iff (wd_rst)
    (restart_p && window_v == CNT_MAX && !(tick && cnt == '0)) |=> !wd_reset);
endmodule

// File: rtl/iwdg_top.sv
module iwdg_top
  import iwdg_pkg::*;
#(
  parameter int PRE_W = 3,
  parameter int CNT_W = 12,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wd_clk,
  input  logic          wd_rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          wd_reset
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             open_q;
  logic [PRE_W-1:0] div_r;
  logic [CNT_W-1:0] reload_r, window_r;
  logic             div_busy, rel_busy, win_busy, cmd_busy;
  logic             div_we, rel_we, win_we, key_wr, cmd_ld;
  logic [PRE_W-1:0] div_s;
  logic [CNT_W-1:0] reload_s, window_s;
  logic             div_p, rel_p, win_p, cmd_p;
  logic [1:0]       cmd_s;

  always_comb begin
    key_wr = wr_en && addr == A_CMD;
    cmd_ld = key_wr && (wr_data == KEY_GO || wr_data == KEY_RESTART);
    div_we = wr_en && addr == A_DIV    && open_q && !div_busy;
    rel_we = wr_en && addr == A_RELOAD && open_q && !rel_busy;
    win_we = wr_en && addr == A_WIN    && open_q && !win_busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q   <= 1'b0;
      div_r    <= '0;
      reload_r <= CNT_MAX;
      window_r <= CNT_MAX;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (key_wr) open_q <= (wr_data == KEY_OPEN);
      if (div_we) div_r    <= wr_data[PRE_W-1:0];
      if (rel_we) reload_r <= wr_data[CNT_W-1:0];
      if (win_we) window_r <= wr_data[CNT_W-1:0];
      rd_valid <= rd_en;
      if (rd_en) begin
        case (addr)
          A_DIV:    rd_data <= DW'(div_r);
          A_RELOAD: rd_data <= DW'(reload_r);
          A_WIN:    rd_data <= DW'(window_r);
          A_STATUS: rd_data <= DW'({win_busy, rel_busy, div_busy});
          default:  rd_data <= '0;
        endcase
      end
    end
  end

  iwdg_xfer #(.W(PRE_W), .RST_VAL('0)) u_div_x (
    .src_clk(clk), .src_rst(rst), .src_load(div_we), .src_data(wr_data[PRE_W-1:0]),
    .src_busy(div_busy), .dst_clk(wd_clk), .dst_rst(wd_rst),
    .dst_data(div_s), .dst_pulse(div_p));

  iwdg_xfer #(.W(CNT_W), .RST_VAL(CNT_MAX)) u_rel_x (
    .src_clk(clk), .src_rst(rst), .src_load(rel_we), .src_data(wr_data[CNT_W-1:0]),
    .src_busy(rel_busy), .dst_clk(wd_clk), .dst_rst(wd_rst),
    .dst_data(reload_s), .dst_pulse(rel_p));

  iwdg_xfer #(.W(CNT_W), .RST_VAL(CNT_MAX)) u_win_x (
    .src_clk(clk), .src_rst(rst), .src_load(win_we), .src_data(wr_data[CNT_W-1:0]),
    .src_busy(win_busy), .dst_clk(wd_clk), .dst_rst(wd_rst),
    .dst_data(window_s), .dst_pulse(win_p));

  // Commands: bit 1 start, bit 0 restart.
  iwdg_xfer #(.W(2), .RST_VAL(2'b00)) u_cmd_x (
    .src_clk(clk), .src_rst(rst), .src_load(cmd_ld),
    .src_data({wr_data == KEY_GO, wr_data == KEY_RESTART}),
    .src_busy(cmd_busy), .dst_clk(wd_clk), .dst_rst(wd_rst),
    .dst_data(cmd_s), .dst_pulse(cmd_p));

  iwdg_core #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_core (
    .wd_clk(wd_clk), .wd_rst(wd_rst), .div_sel(div_s), .reload_v(reload_s),
    .window_v(window_s), .cfg_upd(div_p | rel_p | win_p),
    .go_p(cmd_p && cmd_s[1]), .restart_p(cmd_p && cmd_s[0]), .wd_reset(wd_reset));

  assert_locked_div_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_DIV && !open_q) |=> $stable(div_r));
  assert_relock_R3: assert property (@(posedge clk) disable iff (rst)
    (key_wr && wr_data != KEY_OPEN) |=> !open_q);
  assert_busy_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_RELOAD && rel_busy) |=> $stable(reload_r));
  assert_cmd_hold_R8: assert property (@(posedge clk) disable iff (rst)
    cmd_busy |=> $stable(u_cmd_x.data_q) || !$past(cmd_busy));
endmodule

// File: tb/iwdg_top_tb_top.sv
module iwdg_top_tb_top;
  import iwdg_pkg::*;

  logic clk = 1'b0, wd_clk = 1'b0, rst = 1'b1, wd_rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic rd_valid, wd_reset;

  iwdg_top dut_i (.clk(clk), .rst(rst), .wd_clk(wd_clk), .wd_rst(wd_rst),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .rd_valid(rd_valid), .wd_reset(wd_reset));

  always #4 clk = ~clk;
  always #17 wd_clk = ~wd_clk;

  int checks = 0, fails = 0;
  int exp_q[$];
  string tag_q[$];
  int wd_cyc = 0, rst_cnt = 0, last_edge = 0, wide = 0, wr_t0 = 0;
  logic prev_r = 1'b0;
  bit done = 0;

  always @(posedge wd_clk) wd_cyc <= wd_cyc + 1;

  always @(negedge wd_clk) begin
    if (wd_reset) begin
      rst_cnt++;
      last_edge = wd_cyc;
      if (prev_r) wide++;
    end
    prev_r = wd_reset;
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Scoreboard monitor for reads.
  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) chk(0, "R11 unexpected read", int'(rd_data), -1);
      else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(int'(rd_data) == e, t, int'(rd_data), e);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk);
    wr_t0 = wd_cyc;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input int e, input string t);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_wd(input int n);
    repeat (n) @(negedge wd_clk);
  endtask

  task automatic expect_pulse(input int base, input int t0, input int e, input string t);
    while (rst_cnt == base && wd_cyc < t0 + e + 40) @(negedge wd_clk);
    chk(rst_cnt > base && (last_edge - t0) >= e - 1 && (last_edge - t0) <= e + 1,
        t, last_edge - t0, e);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (4) @(posedge wd_clk);
    @(negedge clk); rst = 1'b0;
    @(negedge wd_clk); wd_rst = 1'b0;
    chk(wd_reset == 1'b0, "R1 reset output", int'(wd_reset), 0);
    rd(A_DIV, 0, "R1 divider reset");
    rd(A_RELOAD, 4095, "R1 reload reset");
    rd(A_WIN, 4095, "R1 window reset");
    rd(A_STATUS, 0, "R1 status reset");
    rd(A_CMD, 0, "R11 command reads zero");

    // Locked write ignored.
    wr(A_DIV, 16'd2);
    rd(A_DIV, 0, "R2 locked write ignored");

    // Open, write reload, see busy; second write while busy dropped.
    wr(A_CMD, KEY_OPEN);
    wr(A_RELOAD, 16'd20);
    rd(A_STATUS, 2, "R4 reload busy bit");
    wr(A_RELOAD, 16'd7);
    wait_wd(20);
    rd(A_STATUS, 0, "R4 status clears");
    rd(A_RELOAD, 20, "R5 write during busy dropped");
    wr(A_RELOAD, 16'd5);
    wr(A_DIV, 16'd0);
    wait_wd(20);
    rd(A_RELOAD, 5, "R2 open write accepted");
    wr(A_CMD, 16'h1234);
    wr(A_DIV, 16'd3);
    wait_wd(10);
    rd(A_DIV, 0, "R3 relocked by other key");
    rd(A_STATUS, 0, "R3 no transfer after relock");

    // Nothing happens before start.
    wait_wd(150);
    chk(rst_cnt == 0, "R6 no pulse before start", rst_cnt, 0);

    // Start: first pulse and steady period.
    base = rst_cnt;
    wr(A_CMD, KEY_GO);
    expect_pulse(base, wr_t0, 4 + 6 * 4, "R7 first timeout div4");
    base = rst_cnt;
    expect_pulse(base, last_edge, 6 * 4, "R9 repeat period");

    // A foreign key does not stop counting.
    wr(A_CMD, 16'h0000);
    base = rst_cnt;
    wait_wd(60);
    chk(rst_cnt > base, "R6 cannot be stopped", rst_cnt - base, 1);

    // Regular restarts keep it quiet.
    base = rst_cnt;
    for (int i = 0; i < 10; i++) begin
      wr(A_CMD, KEY_RESTART);
      wait_wd(10);
    end
    chk(rst_cnt == base, "R8 restarts suppress pulse", rst_cnt - base, 0);
    base = rst_cnt;
    wr(A_CMD, KEY_RESTART);
    expect_pulse(base, wr_t0, 4 + 6 * 4, "R8 timeout after restart");

    // New divider while running.
    wr(A_CMD, KEY_OPEN);
    wr(A_DIV, 16'd1);
    wait_wd(20);
    rd(A_DIV, 1, "R4 divider stored");
    rd(A_STATUS, 0, "R4 divider transfer done");
    wr(A_CMD, 16'h0000);
    base = rst_cnt;
    wr(A_CMD, KEY_RESTART);
    expect_pulse(base, wr_t0, 4 + 6 * 8, "R7 timeout div8");

    // Window: limit 2, divider 16.
    wr(A_CMD, KEY_OPEN);
    wr(A_WIN, 16'd2);
    wr(A_DIV, 16'd2);
    wait_wd(20);
    rd(A_WIN, 2, "R10 window stored");
    wr(A_CMD, 16'h0000);
    base = rst_cnt;
    while (rst_cnt == base) @(negedge wd_clk);
    base = rst_cnt;
    wr(A_CMD, KEY_RESTART);
    expect_pulse(base, wr_t0, 4, "R10 early restart fires");
    wait_wd(46);
    base = rst_cnt;
    wr(A_CMD, KEY_RESTART);
    expect_pulse(base, wr_t0, 4 + 6 * 16, "R10 in-window restart quiet");

    chk(wide == 0, "R9 pulse one cycle wide", wide, 0);
    chk(exp_q.size() == 0, "R11 all reads returned", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule